// File: doc/BRIEF.md
# Dual Fractional Sample Rate Generator

This block decides, frame by frame, which of four converter channels (ADC left, ADC right, DAC left, DAC right) gets a sample slot. Each channel is driven by one of two rate generators. A generator is programmed with a rate in whole hertz. It runs off a fixed 48 kHz serial frame tick and uses phase accumulation, so that over one second it issues exactly as many strobes as the programmed rate.

A control word maps each channel to a generator. The same word can scale the second generator by 8/7 or 10/7. These are the irrational-looking rates that modem sample clocks need. The first generator is never scaled.

The surrounding register decoder writes the two rate registers and the control word through simple write-enable/data pairs. The serial link controller reads one strobe per channel per frame. A high strobe means a sample for that channel is due in that frame.

Top module: `dual_srate_gen`

## Requirements
- R1: While reset is low and after reset, all four strobes are low until the first frame tick. After reset both rates are 48000, every channel is on generator 0 and no scaling is active, so every frame tick strobes all four channels.
- R2: On each frame tick, a generator adds rate×M to its accumulator. M is 7 unscaled, 8 for the 8/7 setting and 10 for the 10/7 setting. If the sum is 336000 or more, the generator strobes and subtracts 336000. The strobe is high in the clock cycle after the edge that samples the tick, and it is low in every other cycle.
- R3: Over 48000 consecutive frame ticks starting from a cleared accumulator, an unscaled generator with a rate from 7000 to 48000 strobes exactly rate times.
- R4: Control bit 5 scales generator 1 by 8/7 and control bit 6 scales it by 10/7. Over 48000 ticks the count is rate×8/7 or rate×10/7, within ±1. If both bits are set, bit 5 takes priority (8/7).
- R5: The scaling bits never change the behaviour of generator 0.
- R6: The control word maps channels to generators with one bit each: bit 8 for ADC left, bit 0 for ADC right, bit 10 for DAC left and bit 2 for DAC right. A 0 selects generator 0 and a 1 selects generator 1. A new mapping applies to the strobes produced from the write edge onward.
- R7: A write to a rate register loads the new rate and clears that generator's accumulator at the same edge. A tick in the write cycle produces no strobe for that generator. The new rate applies from the next tick.
- R8: A control write that changes bits 6:5 clears generator 1's accumulator, and a tick in that cycle produces no strobe for generator 1. A control write that leaves bits 6:5 unchanged does not disturb either accumulator.
- R9: Two channels of a left/right pair that are mapped to the same generator strobe in exactly the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per 48 kHz serial frame |
| rate0_we | input | 1 | Write enable for the generator 0 rate |
| rate0_wdata | input | 16 | Generator 0 rate in Hz |
| rate1_we | input | 1 | Write enable for the generator 1 rate |
| rate1_wdata | input | 16 | Generator 1 rate in Hz |
| ctrl_we | input | 1 | Write enable for the control word |
| ctrl_wdata | input | 16 | Control word: channel mapping bits 0, 2, 8, 10 and scaling bits 5, 6 |
| adc_l_stb | output | 1 | ADC left sample due this frame |
| adc_r_stb | output | 1 | ADC right sample due this frame |
| dac_l_stb | output | 1 | DAC left sample due this frame |
| dac_r_stb | output | 1 | DAC right sample due this frame |

## Verification
Register and control writes take effect at the edge that samples them. A strobe for a tick is due exactly one clock after the edge that samples that tick, and the block has no other latency. The driver applies inputs on the falling edge and, in the same cycle, pushes the strobe vector it predicts from the requirements. The monitor pops one prediction per cycle, 2 ns after the next rising edge, so every comparison falls in the cycle where the strobe is due. Long runs of 48000 back-to-back ticks also count strobes per channel and compare each count with the programmed, and where selected scaled, rate.

// File: rtl/srg_pkg.sv
// Package: shared constants, types and helpers for the dual sample rate
// generator. Assumes two generators and four channels, with control-word
// bit positions fixed by the register decoder that sits next to this block.
package srg_pkg;

    localparam int unsigned N_GEN      = 2;
    localparam int unsigned N_CHAN     = 4;
    localparam int unsigned NUM_W      = 4;
    localparam int unsigned SCALED_GEN = 1;

    // Channel indices used for every per-channel vector in the block.
    localparam int unsigned CH_ADC_L = 0;
    localparam int unsigned CH_ADC_R = 1;
    localparam int unsigned CH_DAC_L = 2;
    localparam int unsigned CH_DAC_R = 3;

    // Control-word bit that selects the generator, per channel index.
    localparam int unsigned SEL_POS [N_CHAN] = '{8, 0, 10, 2};

    // Control-word bits that scale the second generator.
    localparam int unsigned MUL8_POS  = 5;
    localparam int unsigned MUL10_POS = 6;

    typedef enum logic [1:0] {
        MUL_UNITY = 2'd0,
        MUL_8_7   = 2'd1,
        MUL_10_7  = 2'd2
    } mult_e;

    // Decode the raw scaling field {bit6, bit5}; bit 5 wins when both are set.
    function automatic mult_e decode_mult(input logic [1:0] raw);
        if (raw[0])      return MUL_8_7;
        else if (raw[1]) return MUL_10_7;
        else             return MUL_UNITY;
    endfunction

    // Numerator applied against the common denominator of 7.
    function automatic logic [NUM_W-1:0] mult_num(input mult_e m);
        case (m)
            MUL_8_7:  return NUM_W'(8);
            MUL_10_7: return NUM_W'(10);
            default:  return NUM_W'(7);
        endcase
    endfunction

endpackage

// File: rtl/srg_ctrl_regs.sv
// Module: holds the two rate registers and the control word, and raises the
// accumulator clear for each generator. Assumes one write per register per
// cycle; writes land on the rising edge that samples the enable.
module srg_ctrl_regs
    import srg_pkg::*;
#(
    parameter int unsigned RATE_W     = 16,
    parameter int unsigned CTRL_W     = 16,
    parameter int unsigned RESET_RATE = 48000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_GEN-1:0]        rate_we,
    input  logic [RATE_W-1:0]       rate_wdata [N_GEN],
    input  logic                    ctrl_we,
    input  logic [CTRL_W-1:0]       ctrl_wdata,
    output logic [RATE_W-1:0]       rate_q [N_GEN],
    output logic [N_CHAN-1:0]       sel_q,
    output logic [1:0]              mult_raw_q,
    output mult_e                   mult_mode,
    output logic [N_GEN-1:0]        acc_clr
);

    logic [N_CHAN-1:0] sel_next;
    logic [1:0]        mult_next;
    logic              mult_change;

    // Pick the per-channel selection bits out of the incoming control word.
    for (genvar c = 0; c < N_CHAN; c++) begin : g_sel_bits
        assign sel_next[c] = ctrl_wdata[SEL_POS[c]];
    end

    assign mult_next   = {ctrl_wdata[MUL10_POS], ctrl_wdata[MUL8_POS]};
    assign mult_change = ctrl_we && (mult_next != mult_raw_q);

    // One rate register per generator, loaded on its own write enable.
    for (genvar g = 0; g < N_GEN; g++) begin : g_rate
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rate_q[g] <= RATE_W'(RESET_RATE);
            end else if (rate_we[g]) begin
                rate_q[g] <= rate_wdata[g];
            end
        end

        // Clear request: rate write, plus a scaling change for the scaled generator.
        if (g == SCALED_GEN) begin : g_clr_scaled
            assign acc_clr[g] = rate_we[g] | mult_change;
        end else begin : g_clr_plain
            assign acc_clr[g] = rate_we[g];
        end
    end

    // Control word fields: channel mapping and scaling selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= '0;
            mult_raw_q <= '0;
        end else if (ctrl_we) begin
            sel_q      <= sel_next;
            mult_raw_q <= mult_next;
        end
    end

    // Registered scaling field decoded to the mode enum.
    always_comb begin
        mult_mode = decode_mult(mult_raw_q);
    end

endmodule

// File: rtl/srg_phase_acc.sv
// Module: one phase-accumulating rate generator. On each frame tick it adds
// rate*num and strobes when the sum reaches MODULUS. Assumes
// rate*num <= MODULUS, so at most one strobe per tick. A clear request
// overrides a tick in the same cycle.
module srg_phase_acc #(
    parameter int unsigned RATE_W  = 16,
    parameter int unsigned NUM_W   = 4,
    parameter int unsigned MODULUS = 336000,
    localparam int unsigned STEP_W = RATE_W + NUM_W,
    localparam int unsigned ACC_W  = $clog2(MODULUS + (2 ** STEP_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    input  logic [NUM_W-1:0]  num,
    output logic              stb
);

    localparam logic [ACC_W-1:0] MOD_V = ACC_W'(MODULUS);

    logic [STEP_W-1:0] step;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  sum;
    logic              wrap;

    // Phase increment and candidate sum for this frame.
    always_comb begin
        step = STEP_W'(rate) * STEP_W'(num);
        sum  = acc_q + ACC_W'(step);
        wrap = (sum >= MOD_V);
    end

    // Accumulator update and one-cycle strobe per wrapped frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            stb   <= 1'b0;
        end else if (clr) begin
            acc_q <= '0;
            stb   <= 1'b0;
        end else if (tick) begin
            acc_q <= wrap ? (sum - MOD_V) : sum;
            stb   <= wrap;
        end else begin
            stb   <= 1'b0;
        end
    end

endmodule

// File: rtl/srg_chan_router.sv
// Module: steers generator strobes to channel strobes according to the
// per-channel selection bit. Assumes exactly two generators (one select bit).
module srg_chan_router #(
    parameter int unsigned N_CHAN = 4,
    parameter int unsigned N_GEN  = 2
) (
    input  logic [N_GEN-1:0]  gen_stb,
    input  logic [N_CHAN-1:0] sel,
    output logic [N_CHAN-1:0] chan_stb
);

    // Each channel follows the generator its select bit names.
    for (genvar c = 0; c < N_CHAN; c++) begin : g_route
        assign chan_stb[c] = sel[c] ? gen_stb[N_GEN-1] : gen_stb[0];
    end

endmodule

// File: rtl/dual_srate_gen.sv
// Module: top of the dual sample rate generator. It ties together the
// register store, two phase accumulators (the second one scalable) and the
// channel router. Assumes frame_tick is a one-cycle pulse per serial frame
// and that programmed rates, after scaling, lie within 7000..48000 Hz.
module dual_srate_gen
    import srg_pkg::*;
#(
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned CTRL_W   = 16,
    parameter int unsigned FRAME_HZ = 48000,
    parameter int unsigned BASE_DEN = 7,
    localparam int unsigned MODULUS = FRAME_HZ * BASE_DEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              rate0_we,
    input  logic [RATE_W-1:0] rate0_wdata,
    input  logic              rate1_we,
    input  logic [RATE_W-1:0] rate1_wdata,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              adc_l_stb,
    output logic              adc_r_stb,
    output logic              dac_l_stb,
    output logic              dac_r_stb
);

    logic [N_GEN-1:0]  rate_we;
    logic [RATE_W-1:0] rate_wdata [N_GEN];
    logic [RATE_W-1:0] rate_q     [N_GEN];
    logic [N_CHAN-1:0] sel_q;
    logic [1:0]        mult_raw_q;
    mult_e             mult_mode;
    logic [N_GEN-1:0]  acc_clr;
    logic [N_GEN-1:0]  gen_stb;
    logic [N_CHAN-1:0] chan_stb;

    // Gather the per-generator write ports into arrays.
    always_comb begin
        rate_we       = {rate1_we, rate0_we};
        rate_wdata[0] = rate0_wdata;
        rate_wdata[1] = rate1_wdata;
    end

    srg_ctrl_regs #(
        .RATE_W     (RATE_W),
        .CTRL_W     (CTRL_W),
        .RESET_RATE (FRAME_HZ)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_we    (rate_we),
        .rate_wdata (rate_wdata),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .rate_q     (rate_q),
        .sel_q      (sel_q),
        .mult_raw_q (mult_raw_q),
        .mult_mode  (mult_mode),
        .acc_clr    (acc_clr)
    );

    // One accumulator per generator; only the scaled one sees the mode.
    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        logic [NUM_W-1:0] num;

        if (g == SCALED_GEN) begin : g_num_scaled
            assign num = mult_num(mult_mode);
        end else begin : g_num_plain
            assign num = mult_num(MUL_UNITY);
        end

        srg_phase_acc #(
            .RATE_W  (RATE_W),
            .NUM_W   (NUM_W),
            .MODULUS (MODULUS)
        ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (frame_tick),
            .clr   (acc_clr[g]),
            .rate  (rate_q[g]),
            .num   (num),
            .stb   (gen_stb[g])
        );
    end

    srg_chan_router #(
        .N_CHAN (N_CHAN),
        .N_GEN  (N_GEN)
    ) u_route (
        .gen_stb  (gen_stb),
        .sel      (sel_q),
        .chan_stb (chan_stb)
    );

    // Break the channel vector out to named ports.
    always_comb begin
        adc_l_stb = chan_stb[CH_ADC_L];
        adc_r_stb = chan_stb[CH_ADC_R];
        dac_l_stb = chan_stb[CH_DAC_L];
        dac_r_stb = chan_stb[CH_DAC_R];
    end

endmodule

// File: rtl/srg_checker.sv
// Module: temporal checks on the dual sample rate generator. Bound into the
// top so it can see the generator strobes and registered control fields.
module srg_checker #(
    parameter int unsigned CTRL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_tick,
    input logic              rate0_we,
    input logic              rate1_we,
    input logic              ctrl_we,
    input logic [CTRL_W-1:0] ctrl_wdata,
    input logic [1:0]        gen_stb,
    input logic [1:0]        mult_raw_q,
    input logic [3:0]        sel_q,
    input logic              adc_l_stb,
    input logic              adc_r_stb,
    input logic              dac_l_stb,
    input logic              dac_r_stb
);

    // R2
    strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gen_stb) |-> $past(frame_tick));

    // R7
    rate0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rate0_we) |-> !gen_stb[0]);

    // R7
    rate1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rate1_we) |-> !gen_stb[1]);

    // R8
    mult_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_we && ({ctrl_wdata[6], ctrl_wdata[5]} != mult_raw_q)) |-> !gen_stb[1]);

    // R9
    adc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[0] == sel_q[1]) |-> (adc_l_stb == adc_r_stb));

    // R9
    dac_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[2] == sel_q[3]) |-> (dac_l_stb == dac_r_stb));

endmodule

bind dual_srate_gen srg_checker #(.CTRL_W(CTRL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .rate0_we   (rate0_we),
    .rate1_we   (rate1_we),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .gen_stb    (gen_stb),
    .mult_raw_q (mult_raw_q),
    .sel_q      (sel_q),
    .adc_l_stb  (adc_l_stb),
    .adc_r_stb  (adc_r_stb),
    .dac_l_stb  (dac_l_stb),
    .dac_r_stb  (dac_r_stb)
);

// File: tb/sim_dual_srate_gen.sv
// Bench: scoreboard. The driver task predicts each cycle's strobe vector from
// the requirements and queues it; the monitor pops one item per cycle.
module sim_dual_srate_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic        rate0_we = 1'b0;
    logic [15:0] rate0_wdata = '0;
    logic        rate1_we = 1'b0;
    logic [15:0] rate1_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        adc_l_stb, adc_r_stb, dac_l_stb, dac_r_stb;

    int checks = 0;
    int errors = 0;
    int cnt [4];

    logic [3:0] exp_q [$];
    string      tag_q [$];

    // Prediction state.
    longint m_rate0 = 48000, m_rate1 = 48000;
    longint m_acc0 = 0, m_acc1 = 0;
    logic [1:0] m_mb = 2'b00;
    logic [3:0] m_sel = 4'b0000;

    always #4 clk = ~clk;

    dual_srate_gen u0 (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .rate0_we(rate0_we), .rate0_wdata(rate0_wdata),
        .rate1_we(rate1_we), .rate1_wdata(rate1_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .adc_l_stb(adc_l_stb), .adc_r_stb(adc_r_stb),
        .dac_l_stb(dac_l_stb), .dac_r_stb(dac_r_stb)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Drive one cycle of inputs and queue the predicted strobes.
    task automatic step(input logic tick, input logic w0, input logic [15:0] d0,
                        input logic w1, input logic [15:0] d1,
                        input logic wc, input logic [15:0] dc, input string tag);
        logic s0, s1, c0, c1;
        longint m;
        logic [3:0] v;
        @(negedge clk);
        frame_tick = tick; rate0_we = w0; rate0_wdata = d0;
        rate1_we = w1; rate1_wdata = d1; ctrl_we = wc; ctrl_wdata = dc;
        m  = m_mb[0] ? 8 : (m_mb[1] ? 10 : 7);
        c0 = w0;
        c1 = w1 | (wc && ({dc[6], dc[5]} != m_mb));
        s0 = 1'b0; s1 = 1'b0;
        if (c0) m_acc0 = 0;
        else if (tick) begin
            m_acc0 += m_rate0 * 7;
            if (m_acc0 >= 336000) begin s0 = 1'b1; m_acc0 -= 336000; end
        end
        if (c1) m_acc1 = 0;
        else if (tick) begin
            m_acc1 += m_rate1 * m;
            if (m_acc1 >= 336000) begin s1 = 1'b1; m_acc1 -= 336000; end
        end
        if (w0) m_rate0 = d0;
        if (w1) m_rate1 = d1;
        if (wc) begin
            m_mb = {dc[6], dc[5]};
            m_sel = {dc[2], dc[10], dc[0], dc[8]};
        end
        for (int c = 0; c < 4; c++) v[c] = m_sel[c] ? s1 : s0;
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 16'd0, 1'b0, 16'd0, 1'b0, 16'd0, tag);
    endtask

    task automatic check_count(input int c, input int expv, input int tol, input string tag);
        int d;
        checks++;
        d = cnt[c] - expv;
        if (d < 0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s channel %0d count act=%0d exp=%0d", tag, c, cnt[c], expv);
        end
    endtask

    // Program a configuration, then run n back-to-back ticks and count.
    task automatic run_cfg(input logic [15:0] ctl, input logic [15:0] r0,
                           input logic [15:0] r1, input int n, input string tag);
        step(1'b0, 1'b0, 16'd0, 1'b0, 16'd0, 1'b1, ctl, tag);
        step(1'b0, 1'b1, r0, 1'b0, 16'd0, 1'b0, 16'd0, tag);
        step(1'b0, 1'b0, 16'd0, 1'b1, r1, 1'b0, 16'd0, tag);
        idle(tag);
        @(posedge clk); #3;
        for (int c = 0; c < 4; c++) cnt[c] = 0;
        for (int i = 0; i < n; i++)
            step(1'b1, 1'b0, 16'd0, 1'b0, 16'd0, 1'b0, 16'd0, tag);
        idle(tag);
        @(posedge clk); #3;
    endtask

    // Monitor: pop one prediction per cycle and compare, 2 ns after the edge.
    logic [3:0] mon_act, mon_exp;
    string      mon_tag;
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            mon_act = {dac_r_stb, dac_l_stb, adc_r_stb, adc_l_stb};
            checks++;
            if (mon_act !== mon_exp) begin
                errors++;
                $display("FAIL %s strobes act=%b exp=%b", mon_tag, mon_act, mon_exp);
            end
            for (int c = 0; c < 4; c++) cnt[c] += int'(mon_act[c]);
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) cnt[c] = 0;
        repeat (3) @(negedge clk);
        checks++;
        // R1: strobes low while in reset
        if ({dac_r_stb, dac_l_stb, adc_r_stb, adc_l_stb} !== 4'b0000) begin
            errors++;
            $display("FAIL R1 reset strobes act=%b exp=0000",
                     {dac_r_stb, dac_l_stb, adc_r_stb, adc_l_stb});
        end
        rst_n = 1'b1;
        // R1: idle after reset, then defaults strobe every frame
        idle("R1");
        idle("R1");
        for (int i = 0; i < 3; i++)
            step(1'b1, 1'b0, 16'd0, 1'b0, 16'd0, 1'b0, 16'd0, "R1");

        // R7: rate writes coincide with ticks; clear suppresses that strobe
        step(1'b1, 1'b1, 16'd7000, 1'b0, 16'd0, 1'b0, 16'd0, "R7");
        step(1'b1, 1'b0, 16'd0, 1'b1, 16'd44100, 1'b0, 16'd0, "R7");
        for (int i = 0; i < 6; i++)
            step(1'b1, 1'b0, 16'd0, 1'b0, 16'd0, 1'b0, 16'd0, "R7");

        // R3 R6: unscaled, mixed mapping (ADC right and DAC left on generator 1)
        run_cfg(16'h0401, 16'd7000, 16'd44100, 48000, "R3");
        check_count(0, 7000, 0, "R3");
        check_count(1, 44100, 0, "R6");
        check_count(2, 44100, 0, "R6");
        check_count(3, 7000, 0, "R3");

        // R4 R5 R9: 8/7 on generator 1 (DAC pair), generator 0 at 48000 (ADC pair)
        run_cfg(16'h0424, 16'd48000, 16'd22050, 48000, "R4");
        check_count(0, 48000, 0, "R5");
        check_count(1, 48000, 0, "R9");
        check_count(2, 25200, 1, "R4");
        check_count(3, 25200, 1, "R9");

        // R4 R5: 10/7 on generator 1 (ADC pair), generator 0 at 32000 (DAC pair)
        run_cfg(16'h0141, 16'd32000, 16'd11025, 48000, "R4");
        check_count(0, 15750, 1, "R4");
        check_count(1, 15750, 1, "R4");
        check_count(2, 32000, 0, "R5");
        check_count(3, 32000, 0, "R5");

        // R2 R8: sparse ticks, unchanged and changed scaling writes, both bits set
        for (int i = 0; i < 150; i++) begin
            logic t;
            t = (i % 3) != 0;
            if (i == 40)
                step(t, 1'b0, 16'd0, 1'b0, 16'd0, 1'b1, 16'h0141, "R8");
            else if (i == 70)
                step(t, 1'b0, 16'd0, 1'b0, 16'd0, 1'b1, 16'h0064, "R8");
            else if (i == 100)
                step(t, 1'b1, 16'd9000, 1'b0, 16'd0, 1'b1, 16'h0004, "R8");
            else if (i == 120)
                step(t, 1'b0, 16'd0, 1'b1, 16'd40000, 1'b0, 16'd0, "R7");
            else
                step(t, 1'b0, 16'd0, 1'b0, 16'd0, 1'b0, 16'd0, "R2");
        end
        idle("R2");
        @(posedge clk); #3;

        summary();
        $finish;
    end

endmodule